// File: doc/BRIEF.md
# Upward-Growing Operand Stack

This block is the operand store of a zero-address execution unit. Values live in a small register-file RAM inside the block. A stack pointer register always names the next free slot, and the stack grows toward higher addresses. Three commands act on it. A push stores a value at the slot the pointer names and then steps the pointer up. A pop steps the pointer down and then reads the slot it now names. An add removes the two topmost entries and leaves their sum in their place.

Commands arrive over a valid/ready channel. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a command is being worked on, and a producer must hold `cmd_op` and `cmd_data` steady while `cmd_valid` is high and `cmd_ready` is low. Popped values leave as a one-cycle `res_valid` pulse with no back-pressure, so the consumer must take the value in that cycle. The full, empty, busy and error pins are plain levels or pulses.

Top module: `op_stack`

## Requirements
- R1: Values come back in last-in first-out order: a pop returns the most recently pushed entry that has not yet been removed.
- R2: Op code 0 (push) writes `cmd_data` at the slot the pointer names and then advances the pointer by one. `full` is high exactly when the stack holds DEPTH entries.
- R3: Op code 1 (pop) first moves the pointer back by one and then reads that slot. The value appears on `res_data` together with a single-cycle `res_valid` pulse.
- R4: Op code 2 (add) replaces the two topmost entries with their sum modulo 2^DATA_W, for a net pointer change of minus one. It produces no `res_valid` pulse.
- R5: The following commands pulse `err` for one cycle and leave the pointer and the stored contents unchanged: a push when full, a pop when empty, an add with fewer than two entries, and op code 3. Such a command never pulses `res_valid`.
- R6: Reset puts the pointer at base address 0. `empty` is high exactly while the pointer is at the base. After reset the block shows empty high, full low, busy low, and err and res_valid low.
- R7: Every command takes exactly two cycles after acceptance. `busy` is high and `cmd_ready` is low during those cycles. The result, the error pulse and the updated flags all appear at the edge that ends the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 push, 1 pop, 2 add, 3 reserved |
| cmd_data | input | DATA_W | Value to push |
| res_valid | output | 1 | One-cycle pulse: popped value on res_data |
| res_data | output | DATA_W | Popped value |
| busy | output | 1 | Command in progress |
| full | output | 1 | Stack holds DEPTH entries |
| empty | output | 1 | Pointer at base, no entries |
| err | output | 1 | One-cycle pulse: command refused |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. With these values, four pushes reach the full boundary, so the refused push past the top can be exercised, and any pop or add is only a few commands away from the empty and single-entry refusals. The narrow data width lets a chain of adds overflow, so the wrap of the sum modulo 256 is checked directly against a value computed by hand.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_RSV  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FETCH  = 2'd1,
    PH_COMMIT = 2'd2
  } stk_phase_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata_a = cell_q[raddr_a];
  assign rdata_b = cell_q[raddr_b];
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = 4,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  stk_op_e       op,
  output logic [PW-1:0] sp,
  output logic          full,
  output logic          empty,
  output logic          legal,
  output logic [AW-1:0] addr_free,
  output logic [AW-1:0] addr_top,
  output logic [AW-1:0] addr_next
);
  localparam logic [PW-1:0] TOP_LIM = PW'(DEPTH);

  logic [PW-1:0] sp_q;

  assign sp    = sp_q;
  assign full  = (sp_q == TOP_LIM);
  assign empty = (sp_q == '0);

  always_comb begin
    unique case (op)
      OP_PUSH: legal = !full;
      OP_POP:  legal = !empty;
      OP_ADD:  legal = (sp_q >= PW'(2));
      default: legal = 1'b0;
    endcase
  end

  assign addr_free = AW'(sp_q);
  assign addr_top  = AW'(sp_q) - AW'(1);
  assign addr_next = AW'(sp_q) - AW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (upd && legal) begin
      if (op == OP_PUSH) sp_q <= sp_q + PW'(1);
      else               sp_q <= sp_q - PW'(1);
    end
  end

  assert_sp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= TOP_LIM);
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == OP_PUSH && legal) |=> sp_q == $past(sp_q) + PW'(1));
  assert_shrink_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == OP_ADD && legal) |=> sp_q == $past(sp_q) - PW'(1));
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              fetch,
  output logic              commit,
  output stk_op_e           op_q,
  output logic [DATA_W-1:0] data_q
);
  stk_phase_e ph_q;

  assign cmd_ready = (ph_q == PH_IDLE);
  assign busy      = (ph_q != PH_IDLE);
  assign fetch     = (ph_q == PH_FETCH);
  assign commit    = (ph_q == PH_COMMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      op_q   <= OP_PUSH;
      data_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (cmd_valid) begin
          ph_q   <= PH_FETCH;
          op_q   <= stk_op_e'(cmd_op);
          data_q <= cmd_data;
        end
        PH_FETCH:  ph_q <= PH_COMMIT;
        default:   ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));
  assert_fetch_then_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> commit);
  assert_commit_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
endmodule

// File: rtl/op_stack.sv
module op_stack
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              busy,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  logic              fetch, commit, legal, we;
  stk_op_e           op_q;
  logic [DATA_W-1:0] data_q, rd_top, rd_next, opa_q, opb_q, wdata;
  logic [PW-1:0]     sp;
  logic [AW-1:0]     addr_free, addr_top, addr_next, waddr;

  stk_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .fetch(fetch),
    .commit(commit), .op_q(op_q), .data_q(data_q)
  );

  stk_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) ptr_i (
    .clk(clk), .rst_n(rst_n), .upd(commit), .op(op_q), .sp(sp),
    .full(full), .empty(empty), .legal(legal), .addr_free(addr_free),
    .addr_top(addr_top), .addr_next(addr_next)
  );

  assign we    = commit && legal && (op_q == OP_PUSH || op_q == OP_ADD);
  assign waddr = (op_q == OP_PUSH) ? addr_free : addr_next;
  assign wdata = (op_q == OP_PUSH) ? data_q : (opa_q + opb_q);

  stk_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(addr_top), .raddr_b(addr_next),
    .rdata_a(rd_top), .rdata_b(rd_next)
  );

  always_ff @(posedge clk) begin
    if (fetch) begin
      opa_q <= rd_top;
      opb_q <= rd_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      err       <= 1'b0;
    end else begin
      res_valid <= commit && legal && (op_q == OP_POP);
      err       <= commit && !legal;
      if (commit && legal && op_q == OP_POP) res_data <= opa_q;
    end
  end

  assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> sp == $past(sp));
  assert_res_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !err);
  assert_res_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
endmodule

// File: tb/op_stack_tb_top.sv
module op_stack_tb_top;
  localparam int W = 8;
  localparam int D = 4;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [W-1:0] cmd_data = '0;
  logic cmd_ready, res_valid, busy, full, empty, err;
  logic [W-1:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit busy_seen;

  always #2 clk = ~clk;

  op_stack #(.DATA_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .res_valid(res_valid),
    .res_data(res_data), .busy(busy), .full(full), .empty(empty), .err(err)
  );

  // fields: [21:20] op, [19:12] data, [11] res_valid, [10:3] res_data, [2] err, [1] full, [0] empty
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},  // R5 pop empty
    {2'd2, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},  // R5 add empty
    {2'd0, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R2
    {2'd2, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R5 add single
    {2'd0, 8'h0A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R2
    {2'd2, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R4 5+10
    {2'd1, 8'h00, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b1},  // R3
    {2'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'h20, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'h44, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},  // R2 full
    {2'd0, 8'h55, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},  // R5 push full
    {2'd3, 8'h99, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},  // R5 reserved
    {2'd1, 8'h00, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0},  // R1 last in
    {2'd2, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R4 0x20+0x33
    {2'd2, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R4 wrap 0xF0+0x53
    {2'd1, 8'h00, 1'b1, 8'h43, 1'b0, 1'b0, 1'b1}   // R4 sum 0x43
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_seen = busy && !cmd_ready;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    // R6 reset state
    check("R6", "empty", int'(empty), 1);
    check("R6", "full", int'(full), 0);
    check("R6", "busy", int'(busy), 0);
    check("R6", "err", int'(err), 0);
    check("R6", "res_valid", int'(res_valid), 0);
    check("R7", "cmd_ready idle", int'(cmd_ready), 1);

    for (int i = 0; i < NV; i++) begin
      string req;
      logic [21:0] v = VEC[i];
      if (v[2]) req = "R5";
      else if (v[21:20] == 2'd0) req = "R2";
      else if (v[21:20] == 2'd1) req = "R3";
      else req = "R4";
      run_cmd(v[21:20], v[19:12]);
      check(req, "res_valid", int'(res_valid), int'(v[11]));
      if (v[11]) check("R1", "res_data", int'(res_data), int'(v[10:3]));
      check(req, "err", int'(err), int'(v[2]));
      check(req, "full", int'(full), int'(v[1]));
      check("R6", "empty", int'(empty), int'(v[0]));
      check("R7", "busy during cmd", int'(busy_seen), 1);
      check("R7", "idle after cmd", int'(busy), 0);
    end

    // R7: pulses last one cycle only
    @(negedge clk);
    check("R3", "res_valid pulse ends", int'(res_valid), 0);

    // R7: busy for exactly two cycles after acceptance
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 8'h61;
    @(posedge clk);
    @(negedge clk); cmd_valid = 1'b0;
    check("R7", "busy cycle 1", int'(busy), 1);
    check("R7", "ready low cycle 1", int'(cmd_ready), 0);
    @(negedge clk);
    check("R7", "busy cycle 2", int'(busy), 1);
    check("R7", "empty before commit", int'(empty), 1);
    @(negedge clk);
    check("R7", "idle cycle 3", int'(busy), 0);
    check("R2", "not empty after push", int'(empty), 0);

    // R1: LIFO over three values
    run_cmd(2'd0, 8'h62);
    run_cmd(2'd0, 8'h63);
    run_cmd(2'd1, 8'h00);
    check("R1", "lifo 1st", int'(res_data), 8'h63);
    run_cmd(2'd1, 8'h00);
    check("R1", "lifo 2nd", int'(res_data), 8'h62);
    run_cmd(2'd1, 8'h00);
    check("R1", "lifo 3rd", int'(res_data), 8'h61);
    check("R6", "empty after drain", int'(empty), 1);

    // R5: refused pop leaves contents; refused push when full keeps top
    run_cmd(2'd0, 8'h11);
    run_cmd(2'd0, 8'h22);
    run_cmd(2'd0, 8'h33);
    run_cmd(2'd0, 8'h44);
    run_cmd(2'd0, 8'hEE);
    check("R5", "err push full", int'(err), 1);
    run_cmd(2'd1, 8'h00);
    check("R5", "top kept after refused push", int'(res_data), 8'h44);

    // R6: reset returns pointer to base
    do_reset();
    check("R6", "empty after reset", int'(empty), 1);
    check("R6", "full after reset", int'(full), 0);
    run_cmd(2'd1, 8'h00);
    check("R6", "pop after reset refused", int'(err), 1);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule